// File: doc/BRIEF.md
# Multi-pipe receive address matcher

This block decides which receive pipe, if any, an incoming packet is addressed to. The packet's address field arrives as a 40-bit parallel vector with a one-cycle valid strobe. The block compares its low-order bytes against the stored address of each of six pipes. One cycle later it reports a hit and the number of the winning pipe. The compare width is 3, 4 or 5 bytes and is chosen by a two-bit width code.

Pipes 0 and 1 each hold a full five-byte address. Pipes 2 to 5 each store only one byte, their least significant byte, and take their upper four bytes from bits 39:8 of the pipe 1 address. A pipe takes part in matching only when its enable bit is set and its payload width is non-zero. All configuration goes in through one byte-wide write port. Address registers are filled least significant byte first, one byte per write.

Top module: `rx_addr_match`

## Requirements
- R1: After reset the pipe addresses are 0xE7E7E7E7E7 for pipe 0 and 0xC2C2C2C2C2 for pipe 1. The stored low bytes of pipes 2, 3, 4 and 5 are 0xC3, 0xC4, 0xC5 and 0xC6. The width code resets to 2'b11, and `hit` is 0 with `hit_pipe` = 7.
- R2: Width code 2'b01 compares `addr_in[23:0]`, 2'b10 compares `addr_in[31:0]` and 2'b11 compares `addr_in[39:0]`. Input bits above the compare width have no effect.
- R3: While the width code is 2'b00, no probe produces a hit, and address-byte writes are discarded.
- R4: The effective address of pipe p, for p from 2 to 5, is {pipe 1 address[39:8], the stored byte of pipe p}. Rewriting pipe 1 therefore moves the upper bytes of pipes 2 to 5.
- R5: The enable mask resets to 6'b000011, with bit p enabling pipe p. A disabled pipe never produces a hit.
- R6: A pipe whose payload width is 0 never produces a hit. All payload widths reset to 0.
- R7: When several pipes qualify, `hit_pipe` reports the lowest-numbered one.
- R8: `hit` and `hit_pipe` are registered. They reflect the probe presented with `addr_vld` on the previous clock edge. Without a probe, `hit` is 0. Whenever `hit` is 0, `hit_pipe` is 7.
- R9: A write to pipe p's address stores `wr_data` into byte k. The index k is 0 when `wr_first` is 1; otherwise k is the previous address write's index plus one. Bytes with k at or above the configured width are dropped. Pipes 2 to 5 accept only k = 0.
- R10: The value of `wr_sel` picks the write target. Values 0 to 5 select a pipe address, 6 selects the width code in `wr_data[1:0]`, 7 selects the enable mask in `wr_data[5:0]`, and 8+p selects the payload width of pipe p in `wr_data[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 4 | Write target |
| wr_first | input | 1 | Restarts the byte index at 0 for an address write |
| wr_data | input | 8 | Write data |
| addr_vld | input | 1 | Probe strobe for `addr_in` |
| addr_in | input | 40 | Received address, least significant byte in bits 7:0 |
| hit | output | 1 | A qualifying pipe matched the previous probe |
| hit_pipe | output | 3 | Winning pipe number, 7 when there is no hit |

## Verification
The bench first probes with all payload widths still 0. A design that ignored R6 would report pipe 0 there. Pipes 2 to 5 are probed before and after pipe 1 is rewritten; a design that stored full addresses for them, or that read the upper bytes from pipe 0, returns the wrong pipe or a miss. Upper input bytes are corrupted at narrow widths, and a fourth byte is written at width 3. A mask applied to the wrong end of the address, or a byte index that does not stop at the width, shows up as a missed hit or a clobbered upper byte. Several pipes are then made to match at once while enables are removed one at a time. This catches a priority encoder that favours the highest pipe or ignores the enable mask.

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int NPIPE  = 6,
  parameter int AW_MAX = 5,
  parameter int PW_W   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           wr_sel,
  input  logic                 wr_first,
  input  logic [7:0]           wr_data,
  input  logic                 addr_vld,
  input  logic [8*AW_MAX-1:0]  addr_in,
  output logic                 hit,
  output logic [2:0]           hit_pipe
);
  localparam int AB = 8 * AW_MAX;
  localparam logic [3:0] SEL_AW  = 4'd6;
  localparam logic [3:0] SEL_EN  = 4'd7;
  localparam logic [3:0] SEL_PW0 = 4'd8;
  localparam logic [2:0] NO_PIPE = 3'd7;

  logic [1:0]       aw_q;
  logic [NPIPE-1:0] en_q;
  logic [2:0]       wr_idx_q;
  logic [AB-1:0]    full0_q, full1_q;
  logic [AB-1:0]    eff   [NPIPE];
  logic [AB-1:0]    mask;
  logic [NPIPE-1:0] match;
  logic [2:0]       nbytes, idx, sel;

  assign nbytes = (aw_q == 2'd0) ? 3'd0 : {1'b0, aw_q} + 3'd2;
  assign idx    = wr_first ? 3'd0 : wr_idx_q;

  wire addr_wr = wr_en && (wr_sel < 4'(NPIPE));
  wire byte_ok = idx < nbytes;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_q     <= 2'b11;
      en_q     <= NPIPE'(2'b11);
      wr_idx_q <= 3'd0;
      full0_q  <= {AW_MAX{8'hE7}};
      full1_q  <= {AW_MAX{8'hC2}};
    end else begin
      if (wr_en && wr_sel == SEL_AW) aw_q <= wr_data[1:0];
      if (wr_en && wr_sel == SEL_EN) en_q <= wr_data[NPIPE-1:0];
      if (addr_wr && idx != 3'd7) wr_idx_q <= idx + 3'd1;
      if (addr_wr && byte_ok && wr_sel == 4'd0) full0_q[idx*8 +: 8] <= wr_data;
      if (addr_wr && byte_ok && wr_sel == 4'd1) full1_q[idx*8 +: 8] <= wr_data;
    end
  end

  for (genvar b = 0; b < AW_MAX; b++) begin : g_mask
    localparam logic [2:0] BI = 3'(b);
    assign mask[b*8 +: 8] = (BI < nbytes) ? 8'hFF : 8'h00;
  end

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    localparam logic [3:0] PSEL = 4'(p);
    logic [PW_W-1:0] pw_q;

    always_ff @(posedge clk) begin
      if (!rst_n) pw_q <= '0;
      else if (wr_en && wr_sel == SEL_PW0 + PSEL) pw_q <= wr_data[PW_W-1:0];
    end

    if (p == 0) begin : g_p0
      assign eff[p] = full0_q;
    end else if (p == 1) begin : g_p1
      assign eff[p] = full1_q;
    end else begin : g_short
      logic [7:0] lsb_q;
      always_ff @(posedge clk) begin
        if (!rst_n) lsb_q <= 8'hC1 + 8'(p);
        else if (addr_wr && wr_sel == PSEL && idx == 3'd0 && byte_ok) lsb_q <= wr_data;
      end
      assign eff[p] = {full1_q[AB-1:8], lsb_q};
    end

    assign match[p] = en_q[p] && (pw_q != '0) && (nbytes != 3'd0) &&
                      (((addr_in ^ eff[p]) & mask) == '0);
  end

  always_comb begin
    sel = NO_PIPE;
    for (int p = NPIPE - 1; p >= 0; p--)
      if (match[p]) sel = 3'(p);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_pipe <= NO_PIPE;
    end else begin
      hit      <= addr_vld && (match != '0);
      hit_pipe <= (addr_vld && (match != '0)) ? sel : NO_PIPE;
    end
  end
endmodule

module rx_addr_match_chk #(
  parameter int NPIPE = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_vld,
  input logic             hit,
  input logic [2:0]       hit_pipe,
  input logic [1:0]       aw,
  input logic [NPIPE-1:0] en
);
  // R8
  idle_pipe_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_pipe == 3'd7);
  // R8
  hit_follows_probe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(addr_vld));
  // R3
  illegal_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && aw == 2'd0) |=> !hit);
  // R5
  enabled_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((($past(en)) >> hit_pipe) & NPIPE'(1)) != '0);
  // R7
  pipe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> 32'(hit_pipe) < NPIPE);
endmodule

bind rx_addr_match rx_addr_match_chk #(.NPIPE(NPIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .hit(hit),
  .hit_pipe(hit_pipe), .aw(aw_q), .en(en_q)
);

// File: tb/rx_addr_match_tb.sv
module rx_addr_match_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_first = 1'b0, addr_vld = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [39:0] addr_in = '0;
  logic        hit;
  logic [2:0]  hit_pipe;

  int checks = 0, fails = 0;
  logic vld_seen = 1'b0;
  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  rx_addr_match u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_first(wr_first), .wr_data(wr_data), .addr_vld(addr_vld),
    .addr_in(addr_in), .hit(hit), .hit_pipe(hit_pipe)
  );

  always @(posedge clk) vld_seen <= addr_vld;

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (vld_seen) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({hit, hit_pipe} !== e) begin
          fails++;
          $display("FAIL %s: hit/pipe %0d/%0d expected %0d/%0d", t, hit, hit_pipe, e[3], e[2:0]);
        end
      end else if (hit !== 1'b0 || hit_pipe !== 3'd7) begin
        fails++;
        $display("FAIL R8 idle: hit/pipe %0d/%0d expected 0/7", hit, hit_pipe);
      end
    end
  end

  task automatic wr(input logic [3:0] s, input logic [7:0] d, input logic f);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d; wr_first = f;
    @(negedge clk);
    wr_en = 1'b0; wr_first = 1'b0;
  endtask

  task automatic probe(input logic [39:0] a, input logic eh, input logic [2:0] ep, input string t);
    exp_q.push_back({eh, eh ? ep : 3'd7});
    tag_q.push_back(t);
    @(negedge clk);
    addr_vld = 1'b1; addr_in = a;
    @(negedge clk);
    addr_vld = 1'b0;
  endtask

  task automatic wr_addr(input logic [3:0] s, input logic [39:0] a);
    for (int k = 0; k < 5; k++) wr(s, a[k*8 +: 8], k == 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (hit !== 1'b0 || hit_pipe !== 3'd7) begin
      fails++;
      $display("FAIL R1 reset: hit/pipe %0d/%0d expected 0/7", hit, hit_pipe);
    end
    probe(40'hE7E7E7E7E7, 1'b0, 3'd0, "R6 zero width");
    for (int p = 0; p < 6; p++) wr(4'(8 + p), 8'd32, 1'b0);
    probe(40'hE7E7E7E7E7, 1'b1, 3'd0, "R1 pipe0 reset addr");
    probe(40'hC2C2C2C2C2, 1'b1, 3'd1, "R1 pipe1 reset addr");
    probe(40'hC2C2C2C2C3, 1'b0, 3'd0, "R5 pipe2 disabled");
    wr(4'd7, 8'h3F, 1'b0);
    probe(40'hC2C2C2C2C3, 1'b1, 3'd2, "R4 pipe2 borrows pipe1");
    probe(40'hC2C2C2C2C6, 1'b1, 3'd5, "R1 pipe5 reset byte");
    wr(4'd10, 8'd0, 1'b0);
    probe(40'hC2C2C2C2C3, 1'b0, 3'd0, "R6 pipe2 unused");
    wr(4'd10, 8'd32, 1'b0);
    wr(4'd6, 8'h01, 1'b0);
    probe(40'h1234E7E7E7, 1'b1, 3'd0, "R2 width3");
    wr(4'd6, 8'h02, 1'b0);
    probe(40'h55E7E7E7E7, 1'b1, 3'd0, "R2 width4");
    probe(40'h55E7E7E7E6, 1'b0, 3'd0, "R2 width4 miss");
    wr(4'd6, 8'h00, 1'b0);
    probe(40'hE7E7E7E7E7, 1'b0, 3'd0, "R3 illegal width");
    wr(4'd6, 8'h03, 1'b0);
    wr_addr(4'd1, 40'h1122334455);
    probe(40'h1122334455, 1'b1, 3'd1, "R9 pipe1 byte load");
    probe(40'h11223344C3, 1'b1, 3'd2, "R4 new upper bytes");
    probe(40'hC2C2C2C2C3, 1'b0, 3'd0, "R4 old upper gone");
    wr_addr(4'd0, 40'h1122334455);
    wr(4'd2, 8'h55, 1'b1);
    probe(40'h1122334455, 1'b1, 3'd0, "R7 pipe0 wins");
    wr(4'd7, 8'h3E, 1'b0);
    probe(40'h1122334455, 1'b1, 3'd1, "R7 pipe1 wins");
    wr(4'd7, 8'h3C, 1'b0);
    probe(40'h1122334455, 1'b1, 3'd2, "R7 pipe2 wins");
    wr(4'd7, 8'h3F, 1'b0);
    wr(4'd6, 8'h01, 1'b0);
    wr(4'd0, 8'hAA, 1'b1);
    wr(4'd0, 8'hBB, 1'b0);
    wr(4'd0, 8'hCC, 1'b0);
    wr(4'd0, 8'hDD, 1'b0);
    probe(40'hFFFFCCBBAA, 1'b1, 3'd0, "R9 width3 load");
    wr(4'd6, 8'h03, 1'b0);
    probe(40'h1122CCBBAA, 1'b1, 3'd0, "R9 byte beyond width dropped");
    wr(4'd2, 8'h77, 1'b1);
    wr(4'd2, 8'h88, 1'b0);
    probe(40'h1122334477, 1'b1, 3'd2, "R9 short pipe byte0 only");
    probe(40'h1122334488, 1'b0, 3'd0, "R10 no stray pipe byte");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule